// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block is a watchdog timer on a simple register bus. A tick input is divided by a fixed prescaler of four. Each prescaled step decrements a 24-bit down-counter. Software keeps the system alive by writing a two-byte key to a feed location. Each valid key reloads the counter from a programmable timeout constant.

The block is started in two stages. Setting the enable bit only arms the intent. The counter begins to run after the first complete valid key that follows. From then on software cannot stop it. While the watchdog runs, either of two events produces a one-clock reset request:

- the counter expires with the reset-select bit set;
- a key is broken, either because the second byte is wrong or because another bus access falls between the two bytes.

The counter value can be read live at any time.

The bus is a plain single-cycle register interface with no back-pressure. A write is taken on every clock where `bus_wr` is high. A read is taken on every clock where `bus_rd` is high. Read data is combinational from `bus_addr`. A read strobe counts as a bus access for the purpose of breaking a key.

Top module: `wdk_watchdog`

## Requirements
- R1: After reset the mode word reads 0, the timeout constant reads 0xFFFFFF, the counter reads 0xFFFFFF and `rst_req` is low.
- R2: A write to the timeout constant (offset 0x4) stores the written value, with two clamps. A value below 0xFF is stored as 0xFF. A value with any bit set above bit 23 is stored as 0xFFFFFF. The stored value reads back at offset 0x4.
- R3: The offset map is as follows.
  - Offset 0x0 is the mode word: bit 0 enable, bit 1 reset select, bit 2 read-only timeout flag.
  - Offset 0x4 is the timeout constant.
  - Offset 0x8 is the feed location, which is write-only and reads 0.
  - Offset 0xC is the live counter, which is read-only.
  - Every other offset reads 0.
- R4: Once the enable bit is written to 1, writing 0 to it has no effect until reset.
- R5: While the watchdog is not running, the counter does not change except through a valid key. Setting the enable bit alone does not start it.
- R6: A valid key is a write of 0xAA (low byte) to offset 0x8, then a write of 0x55 to offset 0x8 on the next bus access. A valid key loads the counter with the timeout constant, readable in the following cycle. If enable is set, the same key starts the watchdog.
- R7: While running, the counter decrements once for every four cycles with `tick` high. The prescaler restarts at each reload.
- R8: While running, a write of 0xAA followed by a feed write of any other low byte pulses `rst_req` high for one cycle, in the cycle after that write. A lone feed write of a value other than 0xAA is ignored.
- R9: While running, any other read or write between 0xAA and the second byte aborts the key. The abort pulses `rst_req` in the cycle after the intervening access.
- R10: While running, a prescaled step that finds the counter at 0 does three things: it sets the timeout flag (mode bit 2), reloads the counter from the timeout constant, and pulses `rst_req` for one cycle if reset select is 1.
- R11: With reset select 0, expiry sets the timeout flag but leaves `rst_req` low.
- R12: While not running, broken or aborted keys never raise `rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable before the divide-by-four prescaler |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, counts as an access for key aborts |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Three kinds of internal fault are visible at the ports.

- A key checker stuck in the half-open state appears at once: the next unrelated access produces a spurious `rst_req` pulse, or a good key reloads nothing.
- A prescaler or counter fault shows in the live counter readback within four ticked cycles. The bench sweeps the readback cycle by cycle and with gapped ticks, against the value TC minus floor(ticks/4).
- A wrong expiry or arming state shows as a `rst_req` pulse that is absent or misplaced by even one cycle at the computed 4*(TC+1) boundary.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_MODE = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_TC   = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_FEED = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 4'hC;

  localparam logic [7:0] KEY_OPEN  = 8'hAA;
  localparam logic [7:0] KEY_CLOSE = 8'h55;

  typedef enum logic {FD_IDLE = 1'b0, FD_HALF = 1'b1} feed_st_e;

  typedef struct packed {
    logic good;
    logic bad;
  } feed_res_t;
endpackage

// File: rtl/wdk_feed_check.sv
module wdk_feed_check
  import wdk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      feed_wr,
  input  logic [7:0] feed_byte,
  input  logic      other_acc,
  output feed_res_t res
);
  feed_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    res  = '0;
    case (st_q)
      FD_IDLE: begin
        if (feed_wr && feed_byte == KEY_OPEN) st_d = FD_HALF;
      end
      FD_HALF: begin
        if (other_acc) begin
          res.bad = 1'b1;
          st_d    = FD_IDLE;
        end else if (feed_wr) begin
          if (feed_byte == KEY_CLOSE) res.good = 1'b1;
          else                        res.bad  = 1'b1;
          st_d = FD_IDLE;
        end
      end
      default: st_d = FD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= FD_IDLE;
    else        st_q <= st_d;
  end

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FD_IDLE && feed_wr && feed_byte == KEY_OPEN) |=> st_q == FD_HALF); // R6
  AST_HALF_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FD_HALF && (feed_wr || other_acc)) |=> st_q == FD_IDLE); // R9
  AST_VERDICT_NEEDS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (res.good || res.bad) |-> $past(st_d) == FD_HALF || st_q == FD_HALF); // R8
endmodule

// File: rtl/wdk_prescale.sv
module wdk_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  input  logic tick,
  output logic step
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pc_q;

  assign step = run && tick && !clear && (pc_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear)   pc_q <= '0;
    else if (run && tick)  pc_q <= (pc_q == LAST) ? '0 : pc_q + 1'b1;
  end

  AST_STEP_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step); // R7
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(pc_q)); // R5
endmodule

// File: rtl/wdk_countdown.sv
module wdk_countdown #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload,
  input  logic         step,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  assign cnt    = cnt_q;
  assign expire = step && !reload && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '1;
    else if (reload) cnt_q <= load_val;
    else if (step)   cnt_q <= (cnt_q == '0) ? load_val : cnt_q - 1'b1;
  end

  AST_RELOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt_q == $past(load_val)); // R6
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !step) |=> $stable(cnt_q)); // R5
  AST_EXPIRE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cnt_q == $past(load_val)); // R10
endmodule

// File: rtl/wdk_watchdog.sv
module wdk_watchdog
  import wdk_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 24,
  parameter int PRESCALE = 4,
  parameter int TC_MIN   = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  localparam int PAD = DATA_W - CNT_W;
  localparam logic [CNT_W-1:0] TC_FLOOR = CNT_W'(TC_MIN);

  logic             en_q, rsel_q, flag_q, active_q, req_q;
  logic [CNT_W-1:0] tc_q, tc_wval, cnt;
  logic             feed_wr, other_acc, step, expire, over_range;
  feed_res_t        fres;

  assign feed_wr   = bus_wr && (bus_addr == OFS_FEED);
  assign other_acc = bus_rd || (bus_wr && (bus_addr != OFS_FEED));

  assign over_range = |bus_wdata[DATA_W-1:CNT_W];
  always_comb begin
    if (over_range)                          tc_wval = '1;
    else if (bus_wdata[CNT_W-1:0] < TC_FLOOR) tc_wval = TC_FLOOR;
    else                                     tc_wval = bus_wdata[CNT_W-1:0];
  end

  wdk_feed_check i_feed (
    .clk       (clk),
    .rst_n     (rst_n),
    .feed_wr   (feed_wr),
    .feed_byte (bus_wdata[7:0]),
    .other_acc (other_acc),
    .res       (fres)
  );

  wdk_prescale #(.DIV(PRESCALE)) i_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (active_q),
    .clear (fres.good),
    .tick  (tick),
    .step  (step)
  );

  wdk_countdown #(.W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload   (fres.good),
    .step     (step),
    .load_val (tc_q),
    .cnt      (cnt),
    .expire   (expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      rsel_q   <= 1'b0;
      flag_q   <= 1'b0;
      active_q <= 1'b0;
      req_q    <= 1'b0;
      tc_q     <= '1;
    end else begin
      if (bus_wr && bus_addr == OFS_MODE) begin
        en_q   <= en_q | bus_wdata[0];
        rsel_q <= bus_wdata[1];
      end
      if (bus_wr && bus_addr == OFS_TC) tc_q <= tc_wval;
      if (fres.good && en_q) active_q <= 1'b1;
      if (expire) flag_q <= 1'b1;
      req_q <= (expire && rsel_q) || (fres.bad && active_q);
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_MODE: bus_rdata = {{(DATA_W-3){1'b0}}, flag_q, rsel_q, en_q};
      OFS_TC:   bus_rdata = {{PAD{1'b0}}, tc_q};
      OFS_CNT:  bus_rdata = {{PAD{1'b0}}, cnt};
      default:  bus_rdata = '0;
    endcase
  end

  assign rst_req = req_q;

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q); // R4
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> active_q && en_q); // R4
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |=> !rst_req); // R12
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q); // R10
  AST_TC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q >= TC_FLOOR); // R2
  AST_NOSEL_NO_EXPIRE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !rsel_q && !fres.bad) |=> !rst_req); // R11
endmodule

// File: tb/test_wdk_watchdog.sv
module test_wdk_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdk_watchdog i_wdk_watchdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic feed();
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h55);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(4'h0, d); check("R1 mode", d, 32'h0);
    rd(4'h4, d); check("R1 tc", d, 32'hFFFFFF);
    rd(4'hC, d); check("R1 cnt", d, 32'hFFFFFF);
    check("R1 rst_req", {31'b0, rst_req}, 32'h0);

    // R3 unused and write-only offsets read zero
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 4 && a != 12) begin
        rd(a[3:0], d); check("R3 unused read", d, 32'h0);
      end
    end

    // R2 clamp sweep around the floor
    for (int v = 32'hF8; v <= 32'h108; v++) begin
      wr(4'h4, v);
      rd(4'h4, d);
      check("R2 tc clamp", d, (v < 255) ? 32'hFF : v);
    end
    wr(4'h4, 32'h0100_0000); rd(4'h4, d); check("R2 over range", d, 32'hFFFFFF);
    wr(4'h4, 32'h0);         rd(4'h4, d); check("R2 zero", d, 32'hFF);
    wr(4'h4, 32'hFFFFFF);    rd(4'h4, d); check("R2 max", d, 32'hFFFFFF);

    // R5 enable alone does not start
    tick = 1'b1;
    wr(4'h0, 32'h3);
    idle(20);
    rd(4'hC, d); check("R5 not started", d, 32'hFFFFFF);
    rd(4'h0, d); check("R3 mode bits", d, 32'h3);

    // R4 enable sticky
    wr(4'h0, 32'h0);
    rd(4'h0, d); check("R4 enable sticky", d, 32'h1);
    wr(4'h0, 32'h3);

    // R6/R7 reload and cycle-by-cycle decrement
    wr(4'h4, 32'h100);
    feed();
    for (int m = 0; m <= 40; m++) begin
      rd(4'hC, d); check("R7 count sweep", d, 32'h100 - m / 4);
    end

    // R7 gapped ticks
    tick = 1'b0;
    feed();
    rd(4'hC, d); check("R6 reload", d, 32'h100);
    for (int j = 0; j < 12; j++) begin
      tick = 1'b1; idle(1); tick = 1'b0; idle(2);
      rd(4'hC, d); check("R7 gapped ticks", d, 32'h100 - (j + 1) / 4);
    end

    // R10 expiry with reset select
    do_reset();
    tick = 1'b1;
    wr(4'h0, 32'h3);
    wr(4'h4, 32'hFF);
    feed();
    idle(1023);
    check("R10 no early req", {31'b0, rst_req}, 32'h0);
    idle(1);
    check("R10 req pulse", {31'b0, rst_req}, 32'h1);
    rd(4'h0, d); check("R10 flag", d, 32'h7);
    check("R10 single pulse", {31'b0, rst_req}, 32'h0);
    rd(4'hC, d); check("R10 counter reloaded", d, 32'hFF);

    // R11 expiry without reset select
    do_reset();
    wr(4'h0, 32'h1);
    wr(4'h4, 32'hFF);
    feed();
    idle(1024);
    check("R11 no req", {31'b0, rst_req}, 32'h0);
    rd(4'h0, d); check("R11 flag", d, 32'h5);

    // R8 broken second byte while running
    do_reset();
    wr(4'h0, 32'h3);
    feed();
    foreach (d[i]) begin end
    for (int k = 0; k < 5; k++) begin
      logic [31:0] bv;
      bv = (k == 0) ? 32'h00 : (k == 1) ? 32'hAA : (k == 2) ? 32'h54 : (k == 3) ? 32'h56 : 32'hFF;
      wr(4'h8, 32'hAA);
      wr(4'h8, bv);
      check("R8 bad key req", {31'b0, rst_req}, 32'h1);
      idle(1);
      check("R8 req ends", {31'b0, rst_req}, 32'h0);
    end
    wr(4'h8, 32'h12);
    check("R8 lone write ignored", {31'b0, rst_req}, 32'h0);
    wr(4'h8, 32'h55);
    check("R8 lone close ignored", {31'b0, rst_req}, 32'h0);
    feed();
    check("R6 good key no req", {31'b0, rst_req}, 32'h0);

    // R9 interrupted key
    wr(4'h8, 32'hAA);
    rd(4'h0, d);
    check("R9 read aborts", {31'b0, rst_req}, 32'h1);
    wr(4'h8, 32'hAA);
    wr(4'h4, 32'h200);
    check("R9 write aborts", {31'b0, rst_req}, 32'h1);

    // R12 not running: broken keys harmless; R5/R6 staging
    do_reset();
    wr(4'h0, 32'h2);
    wr(4'h4, 32'h300);
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h12);
    check("R12 bad key unarmed", {31'b0, rst_req}, 32'h0);
    feed();
    rd(4'hC, d); check("R6 reload unarmed", d, 32'h300);
    idle(10);
    rd(4'hC, d); check("R5 frozen unarmed", d, 32'h300);
    wr(4'h0, 32'h3);
    idle(10);
    rd(4'hC, d); check("R5 enable before feed", d, 32'h300);
    wr(4'h8, 32'hAA);
    rd(4'h0, d);
    check("R12 abort unarmed", {31'b0, rst_req}, 32'h0);
    feed();
    idle(8);
    rd(4'hC, d); check("R6 arms after enable", d, 32'h300 - 2);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule